// File: doc/BRIEF.md
# Three-Lane Stereo Serial Audio Transmitter

This block sends stereo 16-bit audio to external converters as a clock master. It runs from a clock at 512 times the audio frame rate. From that clock it makes an oversampling clock at 256 times the frame rate, a bit clock and a word strobe. The bit clock and word strobe are shared by three serial data lanes. Each lane carries its own left and right sample, using standard I2S framing. Every frame lasts exactly 512 input clock cycles, in either frame format.

There are two frame formats. In the short format a frame is 32 bit clocks and the two words follow each other with no gap. In the long format a frame is 64 bit clocks, and each 32-bit channel slot is the 16-bit word followed by 16 zero bits. A format change requested in the middle of a frame waits for the next frame boundary.

Samples for all three lanes arrive as one wide word on a valid/ready stream into a one-entry buffer. At each frame boundary the buffered set becomes the current set, and a request pulse asks for the set of the following frame. The source may hold `s_valid` low at any time; `s_ready` stays high until a set is taken and low until the next boundary. If nothing is buffered at a boundary, the previous set is sent again and an underrun flag is shown for that frame.

Top module: `i2s_multilane_tx`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), `bck_o`, `ws_o`, `osck_o`, `sd_o`, `req_o` and `underrun_o` are 0 and `s_ready` is 1. The first frame after reset uses the short format and all-zero samples.
- R2: `osck_o` toggles on every clock edge, so it is half the clock rate (256 times the frame rate). A frame is 512 clock cycles, and the outputs follow a free-running frame phase by one register stage.
- R3: In the short format (`fmt64_i` = 0), a bit lasts 16 clocks. `bck_o` is low for the first 8 clocks of each bit and high for the last 8, and a frame holds 32 bits.
- R4: In the long format (`fmt64_i` = 1), a bit lasts 8 clocks, with `bck_o` low for 4 and high for 4, and a frame holds 64 bits.
- R5: `ws_o` is 0 over the left half of each frame and 1 over the right half. It changes only where `bck_o` falls.
- R6: Each word is sent MSB first, starting one bit after the `ws_o` edge of its slot. `sd_o` changes only where `bck_o` falls.
- R7: In the short format, the right word follows the left word with no gap. Bit 0 of a frame carries the right-channel LSB of the previous frame's set.
- R8: In the long format, each 32-bit slot sends the 16 data bits and then zeros. Bit 0 of each slot is therefore also zero.
- R9: Lane L takes its left word from `s_data[32L+31:32L+16]` and its right word from `s_data[32L+15:32L]`. All lanes share `bck_o` and `ws_o`.
- R10: A set is accepted on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` is high exactly when the buffer is empty, and the buffer is emptied only at a frame boundary.
- R11: `req_o` is high for the single cycle that follows each frame boundary edge.
- R12: If the buffer is empty at a boundary, the previous set is sent again. `underrun_o` is then 1 from that boundary until the next one, and it is 0 for frames that received a fresh set.
- R13: A change of `fmt64_i` takes effect only at the next frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at 512 times the frame rate |
| rst_n | input | 1 | Synchronous reset, active low |
| fmt64_i | input | 1 | Frame format: 0 = 32 bit clocks, 1 = 64 bit clocks |
| s_valid | input | 1 | A sample set is offered |
| s_ready | output | 1 | The buffer can take a set |
| s_data | input | 96 | Left/right words for the three lanes |
| req_o | output | 1 | One-cycle request for the next frame's set |
| underrun_o | output | 1 | The current frame repeats the previous set |
| bck_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word strobe, 1 = right channel |
| osck_o | output | 1 | Oversampling clock, 256 times the frame rate |
| sd_o | output | 3 | Serial data, one bit per lane |

## Verification
The bench uses the default build of three lanes. With that build, a full frame of 512 clocks is short enough to compare every output on every cycle against an arithmetic model for 24 frames. That run covers both formats and format changes requested mid-frame. It also covers underruns of one and two frames, and sources that offer data late in the frame, so the wrap of the short-format LSB into the next frame and the zero padding of the long format are both reached many times.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam int SAMPLE_W   = 16;
  localparam int SET_W      = 2 * SAMPLE_W;
  localparam int FRAME_CLKS = 512;
  localparam int PH_W       = $clog2(FRAME_CLKS);
  localparam int POS_W      = $clog2(SAMPLE_W);

  typedef enum logic {
    FMT_SHORT = 1'b0,
    FMT_LONG  = 1'b1
  } fmt_e;
endpackage

// File: rtl/i2s_tx_timing.sv
module i2s_tx_timing
  import i2s_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fmt_i,
  output logic             frame_end_o,
  output fmt_e             fmt_o,
  output logic             chan_o,
  output logic [POS_W-1:0] pos_o,
  output logic             pad_o,
  output logic             use_prev_o,
  output logic             bck_o,
  output logic             ws_o,
  output logic             osck_o
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAME_CLKS - 1);

  logic [PH_W-1:0] ph;
  fmt_e            fmt_q;
  logic [5:0]      prev_bit_long;
  logic [4:0]      prev_bit_short;
  logic            bck_n;

  assign frame_end_o = (ph == PH_LAST);
  assign fmt_o       = fmt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= '0;
      fmt_q <= FMT_SHORT;
    end else begin
      ph <= ph + 1'b1;
      if (frame_end_o) fmt_q <= fmt_e'(fmt_i);
    end
  end

  // position of the bit on the line, one bit behind the strobe
  always_comb begin
    prev_bit_long  = ph[8:3] - 6'd1;
    prev_bit_short = ph[8:4] - 5'd1;
    if (fmt_q == FMT_LONG) begin
      chan_o     = prev_bit_long[5];
      pos_o      = prev_bit_long[3:0];
      pad_o      = prev_bit_long[4];
      use_prev_o = 1'b0;
      bck_n      = ph[2];
    end else begin
      chan_o     = prev_bit_short[4];
      pos_o      = prev_bit_short[3:0];
      pad_o      = 1'b0;
      use_prev_o = (ph[8:4] == 5'd0);
      bck_n      = ph[3];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bck_o  <= 1'b0;
      ws_o   <= 1'b0;
      osck_o <= 1'b0;
    end else begin
      bck_o  <= bck_n;
      ws_o   <= ph[PH_W-1];
      osck_o <= ph[0];
    end
  end

  assert_osck_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    osck_o |=> !osck_o) else $error("osck did not toggle");
endmodule

// File: rtl/i2s_tx_feed.sv
module i2s_tx_feed
  import i2s_tx_pkg::*;
#(
  parameter int LANES = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_end_i,
  input  logic                   s_valid,
  output logic                   s_ready,
  input  logic [LANES*SET_W-1:0] s_data,
  output logic [LANES*SET_W-1:0] cur_o,
  output logic [LANES-1:0]       prev_lsb_o,
  output logic                   req_o,
  output logic                   underrun_o
);
  logic [LANES*SET_W-1:0] hold;
  logic                   hold_full;
  logic                   take;

  assign s_ready = !hold_full;
  assign take    = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold       <= '0;
      hold_full  <= 1'b0;
      cur_o      <= '0;
      prev_lsb_o <= '0;
      req_o      <= 1'b0;
      underrun_o <= 1'b0;
    end else begin
      req_o <= frame_end_i;
      if (frame_end_i) begin
        for (int l = 0; l < LANES; l++) prev_lsb_o[l] <= cur_o[l*SET_W];
        underrun_o <= !hold_full;
        if (hold_full) begin
          cur_o     <= hold;
          hold_full <= 1'b0;
        end
      end
      if (take) begin
        hold      <= s_data;
        hold_full <= 1'b1;
      end
    end
  end

  assert_take_fills_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready) else $error("ready after accept");
  assert_req_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o) else $error("request longer than one cycle");
  assert_underrun_frame_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(underrun_o) |-> req_o) else $error("underrun moved inside frame");
endmodule

// File: rtl/i2s_tx_lane.sv
module i2s_tx_lane
  import i2s_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                prev_lsb_i,
  input  logic                chan_i,
  input  logic [POS_W-1:0]    pos_i,
  input  logic                pad_i,
  input  logic                use_prev_i,
  output logic                sd_o
);
  logic [SAMPLE_W-1:0] word;
  logic                bit_n;

  always_comb begin
    word = chan_i ? right_i : left_i;
    if (use_prev_i)  bit_n = prev_lsb_i;
    else if (pad_i)  bit_n = 1'b0;
    else             bit_n = word[POS_W'(SAMPLE_W - 1) - pos_i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sd_o <= 1'b0;
    else        sd_o <= bit_n;
  end
endmodule

// File: rtl/i2s_multilane_tx.sv
module i2s_multilane_tx
  import i2s_tx_pkg::*;
#(
  parameter int LANES = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fmt64_i,
  input  logic                   s_valid,
  output logic                   s_ready,
  input  logic [LANES*SET_W-1:0] s_data,
  output logic                   req_o,
  output logic                   underrun_o,
  output logic                   bck_o,
  output logic                   ws_o,
  output logic                   osck_o,
  output logic [LANES-1:0]       sd_o
);
  logic                   frame_end;
  fmt_e                   fmt_cur;
  logic                   chan;
  logic [POS_W-1:0]       pos;
  logic                   pad;
  logic                   use_prev;
  logic [LANES*SET_W-1:0] cur;
  logic [LANES-1:0]       prev_lsb;

  i2s_tx_timing u_timing (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt64_i), .frame_end_o(frame_end),
    .fmt_o(fmt_cur), .chan_o(chan), .pos_o(pos), .pad_o(pad),
    .use_prev_o(use_prev), .bck_o(bck_o), .ws_o(ws_o), .osck_o(osck_o)
  );

  i2s_tx_feed #(.LANES(LANES)) u_feed (
    .clk(clk), .rst_n(rst_n), .frame_end_i(frame_end), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .cur_o(cur), .prev_lsb_o(prev_lsb),
    .req_o(req_o), .underrun_o(underrun_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    i2s_tx_lane u_lane (
      .clk(clk), .rst_n(rst_n),
      .left_i(cur[l*SET_W+SET_W-1 -: SAMPLE_W]),
      .right_i(cur[l*SET_W+SAMPLE_W-1 -: SAMPLE_W]),
      .prev_lsb_i(prev_lsb[l]), .chan_i(chan), .pos_i(pos), .pad_i(pad),
      .use_prev_i(use_prev), .sd_o(sd_o[l])
    );
  end

  assert_ws_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws_o) |-> $fell(bck_o)) else $error("strobe moved off a falling bit clock");
  assert_data_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd_o) |-> $fell(bck_o)) else $error("data moved off a falling bit clock");
  assert_fmt_at_boundary_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fmt_cur) |-> req_o) else $error("format changed inside a frame");
endmodule

// File: tb/i2s_multilane_tx_test.sv
module i2s_multilane_tx_test;
  localparam int LANES = 3;
  localparam int DW    = LANES * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fmt64_i = 1'b0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [DW-1:0] s_data = '0;
  logic          req_o, underrun_o, bck_o, ws_o, osck_o;
  logic [LANES-1:0] sd_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  i2s_multilane_tx #(.LANES(LANES)) uut (
    .clk(clk), .rst_n(rst_n), .fmt64_i(fmt64_i), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .req_o(req_o), .underrun_o(underrun_o),
    .bck_o(bck_o), .ws_o(ws_o), .osck_o(osck_o), .sd_o(sd_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] make_set(input int k);
    logic [DW-1:0] v;
    for (int l = 0; l < LANES; l++) begin
      v[l*32+31 -: 16] = 16'(k * 40503 + l * 7919 + 16'h8001);
      v[l*32+15 -: 16] = 16'((k + 3) * 25173 ^ (l * 13849) ^ 16'h00FF);
    end
    return v;
  endfunction

  function automatic logic exp_bit(input int l, input int n, input bit md,
                                   input logic [DW-1:0] cur, input logic [LANES-1:0] prv);
    int p, nb, s, b, q, ch, pos;
    logic [15:0] w;
    p  = md ? 8 : 16;
    nb = 512 / p;
    s  = nb / 2;
    b  = n / p;
    q  = (b + nb - 1) % nb;
    ch = q / s;
    pos = q % s;
    if (!md && b == 0) return prv[l];
    if (pos >= 16) return 1'b0;
    w = ch ? cur[l*32+15 -: 16] : cur[l*32+31 -: 16];
    return w[15-pos];
  endfunction

  initial begin
    logic [DW-1:0] cur_m, hold_m;
    logic [LANES-1:0] prv_m;
    bit hf_m, mode_m, req_m, und_m, acc, em;
    int t, n, nxt, fr, pb, p;
    logic e_bck, e_ws, e_osck;
    logic [LANES-1:0] e_sd;
    string tg;
    cur_m = '0; hold_m = '0; prv_m = '0; hf_m = 0; mode_m = 0;
    req_m = 0; und_m = 0; nxt = 0; t = 0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 bck", int'(bck_o), 0);
    chk("R1 ws", int'(ws_o), 0);
    chk("R1 osck", int'(osck_o), 0);
    chk("R1 sd", int'(sd_o), 0);
    chk("R1 req", int'(req_o), 0);
    chk("R1 underrun", int'(underrun_o), 0);
    chk("R1 ready", int'(s_ready), 1);
    rst_n = 1'b1;
    s_data = make_set(0);
    while (t < 24 * 512 + 40) begin
      @(posedge clk);
      t++;
      n  = (t - 1) % 512;
      em = mode_m;
      p  = em ? 8 : 16;
      e_bck  = (n % p) >= p / 2;
      e_ws   = n >= 256;
      e_osck = n[0];
      for (int l = 0; l < LANES; l++) e_sd[l] = exp_bit(l, n, em, cur_m, prv_m);
      acc = s_valid && !hf_m;
      req_m = 0;
      if (t % 512 == 0) begin
        und_m = !hf_m;
        for (int l = 0; l < LANES; l++) prv_m[l] = cur_m[l*32];
        if (hf_m) begin cur_m = hold_m; hf_m = 0; end
        mode_m = fmt64_i;
        req_m = 1;
      end
      if (acc) begin hold_m = s_data; hf_m = 1; nxt++; end
      @(negedge clk);
      chk("R2 osck", int'(osck_o), int'(e_osck));
      tg = (fmt64_i != em) ? "R13 bck" : (em ? "R4 bck" : "R3 bck");
      chk(tg, int'(bck_o), int'(e_bck));
      chk("R5 ws", int'(ws_o), int'(e_ws));
      for (int l = 0; l < LANES; l++) begin
        if (l == LANES - 1) tg = "R9 lane";
        else if (em && ((n / 8) % 32 == 0 || (n / 8) % 32 > 16)) tg = "R8 pad";
        else if (!em && n < 16) tg = "R7 wrap";
        else tg = "R6 data";
        chk(tg, int'(sd_o[l]), int'(e_sd[l]));
      end
      chk("R10 ready", int'(s_ready), int'(!hf_m));
      chk("R11 req", int'(req_o), int'(req_m));
      chk("R12 underrun", int'(underrun_o), int'(und_m));
      // next stimulus
      fr = t / 512;
      pb = t % 512;
      fmt64_i = 1'(((t + 212) / 2048) % 2);
      if (fr == 3 || fr == 7 || fr == 8 || fr == 14) s_valid = 1'b0;
      else s_valid = (pb >= (fr % 3) * 150);
      s_data = make_set(nxt);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule